// File: doc/BRIEF.md
# Waveform Run-Length Compressor

This block watches a multi-bit sampled signal, taking at most one sample per clock through a valid/ready handshake. It sends out short records in place of raw samples. An unbroken stretch of equal samples becomes a single run. A run ends in one of three ways: the value changes, the run counter fills up, or a flush is requested. Each ending produces one record with three fields: the level that was held, a change mask, and the number of samples the run lasted.

A record caused by a value change carries the bitwise XOR of the old and new values in its mask. A record caused by the counter limit or by a flush carries an all-zero mask. From these records, a downstream consumer can rebuild the original sample sequence exactly. Records leave through a one-entry output register with a valid/ready handshake. While that register holds a record the consumer has not taken, new input samples are refused.

Top module: `rlc_compressor`

## Requirements
- R1: After reset, `rec_valid` is 0 and `smp_ready` is 1.
- R2: The first sample accepted after reset, or after a flush has closed the run, starts a new run with a count of 1 and produces no record.
- R3: An accepted sample equal to the current run level, while the count is below 65,535, adds one to the count and produces no record.
- R4: An accepted sample that differs from the run level produces one record: `rec_prev` is the old level, `rec_mask` is the old level XOR the new sample (a 1 marks each flipped bit), and `rec_len` is the old count. A new run then starts at the new value with a count of 1.
- R5: The count field is 16 bits wide. If an equal sample arrives when the count is already 65,535, the block produces a record with the level, a zero mask and length 65,535, and restarts the count at 1 at the same level.
- R6: A flush that the block accepts while a run is open produces a record with the level, a zero mask and the current count, and then closes the run. A flush with no open run produces nothing.
- R7: While `flush_req` is high, `smp_ready` is 0. A flush and a sample are therefore never accepted in the same cycle.
- R8: `smp_ready` equals (`rec_valid` is 0 OR `rec_ready` is 1) AND `flush_req` is 0. While `rec_valid` is 1 and `rec_ready` is 0, every record field stays unchanged.
- R9: `rec_len` is never 0 while `rec_valid` is 1.
- R10: Every accepted sample is counted in exactly one record, and records come out in the order the runs ended. No record is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | A sample is offered |
| smp_data | input | W | Sample value |
| smp_ready | output | 1 | The block takes the offered sample this cycle |
| flush_req | input | 1 | Request to close the open run (taken when the output register is free) |
| rec_valid | output | 1 | A record is presented |
| rec_ready | input | 1 | The consumer takes the record this cycle |
| rec_prev | output | W | Level held during the run |
| rec_mask | output | W | Bits that flipped at the run end (zero for limit or flush records) |
| rec_len | output | CNT_W | Number of samples in the run |

## Verification
A flush request and an arriving sample can fall in the same cycle. The bench provokes this both in a directed step and at random. Each time, it checks that `smp_ready` is low while the flush is present. It also checks that the held sample enters the next cycle as the first sample of a fresh run, with no transition record against the flushed level. Every record is compared with a model in the bench that is built only from the accepted handshakes, and the counter-limit split is reached with one long constant stretch of samples.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    typedef enum logic [1:0] {
        END_NONE   = 2'd0,
        END_CHANGE = 2'd1,
        END_SPLIT  = 2'd2,
        END_FLUSH  = 2'd3
    } run_end_e;

endpackage

// File: rtl/rlc_diff.sv
module rlc_diff #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    output logic [W-1:0] flip_mask,
    output logic         differs
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign flip_mask[b] = old_val[b] ^ new_val[b];
    end

    assign differs = |flip_mask;

endmodule

// File: rtl/rlc_run_tracker.sv
module rlc_run_tracker
    import rlc_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [W-1:0]     sample,
    input  logic             flush_take,
    output logic             emit,
    output logic [W-1:0]     emit_prev,
    output logic [W-1:0]     emit_mask,
    output logic [CNT_W-1:0] emit_len
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic [W-1:0]     level;
        logic [CNT_W-1:0] count;
    } run_t;

    run_t     run_d, run_q;
    run_end_e why;

    logic [W-1:0] flips;
    logic         changed;

    rlc_diff #(.W(W)) u_diff (
        .old_val   (run_q.level),
        .new_val   (sample),
        .flip_mask (flips),
        .differs   (changed)
    );

    always_comb begin
        run_d     = run_q;
        emit      = 1'b0;
        why       = END_NONE;
        emit_prev = run_q.level;
        emit_mask = '0;
        emit_len  = run_q.count;
        if (flush_take) begin
            if (run_q.active) begin
                emit = 1'b1;
                why  = END_FLUSH;
            end
            run_d.active = 1'b0;
            run_d.count  = '0;
        end else if (take) begin
            if (!run_q.active) begin
                run_d.active = 1'b1;
                run_d.level  = sample;
                run_d.count  = CNT_ONE;
            end else if (changed) begin
                emit        = 1'b1;
                why         = END_CHANGE;
                emit_mask   = flips;
                run_d.level = sample;
                run_d.count = CNT_ONE;
            end else if (run_q.count == CNT_MAX) begin
                emit        = 1'b1;
                why         = END_SPLIT;
                run_d.count = CNT_ONE;
            end else begin
                run_d.count = run_q.count + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // R2: opening a run never produces a record
    p_open_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take && !run_q.active |-> !emit);

    // R4: a change record always has at least one flipped bit
    p_change_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        emit && why == END_CHANGE |-> emit_mask != '0);

    // R5: a split record happens only at a full counter
    p_split_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit && why == END_SPLIT |-> emit_len == CNT_MAX && emit_mask == '0);

    // R6: an accepted flush leaves no run open
    p_flush_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_take |=> !run_q.active);

    // R7: a flush and a sample are never taken together
    p_no_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_take && take));

    // R9: an open run always has a nonzero count
    p_run_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.active |-> run_q.count != '0);

endmodule

// File: rtl/rlc_out_stage.sv
module rlc_out_stage #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     in_prev,
    input  logic [W-1:0]     in_mask,
    input  logic [CNT_W-1:0] in_len,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [W-1:0]     out_prev,
    output logic [W-1:0]     out_mask,
    output logic [CNT_W-1:0] out_len,
    output logic             free
);

    typedef struct packed {
        logic             valid;
        logic [W-1:0]     prev;
        logic [W-1:0]     mask;
        logic [CNT_W-1:0] len;
    } slot_t;

    slot_t slot_d, slot_q;

    assign free = !slot_q.valid || out_ready;

    always_comb begin
        slot_d = slot_q;
        if (free) begin
            slot_d.valid = load;
            if (load) begin
                slot_d.prev = in_prev;
                slot_d.mask = in_mask;
                slot_d.len  = in_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_prev  = slot_q.prev;
    assign out_mask  = slot_q.mask;
    assign out_len   = slot_q.len;

    // R8: a stalled record holds every field
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_prev)
                                   && $stable(out_mask) && $stable(out_len));

    // R10: a record is offered only when the slot can take it
    p_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> free);

    // R9: a presented record never has zero length
    p_len_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != '0);

endmodule

// File: rtl/rlc_compressor.sv
module rlc_compressor #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [W-1:0]     smp_data,
    output logic             smp_ready,
    input  logic             flush_req,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [W-1:0]     rec_prev,
    output logic [W-1:0]     rec_mask,
    output logic [CNT_W-1:0] rec_len
);

    logic             slot_free;
    logic             take;
    logic             flush_take;
    logic             emit;
    logic [W-1:0]     emit_prev;
    logic [W-1:0]     emit_mask;
    logic [CNT_W-1:0] emit_len;

    assign smp_ready  = slot_free && !flush_req;
    assign take       = smp_valid && smp_ready;
    assign flush_take = flush_req && slot_free;

    rlc_run_tracker #(.W(W), .CNT_W(CNT_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .sample     (smp_data),
        .flush_take (flush_take),
        .emit       (emit),
        .emit_prev  (emit_prev),
        .emit_mask  (emit_mask),
        .emit_len   (emit_len)
    );

    rlc_out_stage #(.W(W), .CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (emit),
        .in_prev   (emit_prev),
        .in_mask   (emit_mask),
        .in_len    (emit_len),
        .out_ready (rec_ready),
        .out_valid (rec_valid),
        .out_prev  (rec_prev),
        .out_mask  (rec_mask),
        .out_len   (rec_len),
        .free      (slot_free)
    );

    // R7: a pending flush blocks sample intake
    p_flush_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !smp_ready);

    // R8: a stalled record blocks sample intake
    p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |-> !smp_ready);

endmodule

// File: tb/rlc_compressor_bench.sv
module rlc_compressor_bench;

    localparam int unsigned W     = 8;
    localparam int unsigned CNT_W = 16;
    localparam int          LIMIT = 65535;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [W-1:0]     smp_data = '0;
    logic             smp_ready;
    logic             flush_req = 1'b0;
    logic             rec_valid;
    logic             rec_ready = 1'b0;
    logic [W-1:0]     rec_prev;
    logic [W-1:0]     rec_mask;
    logic [CNT_W-1:0] rec_len;

    always #2.5 clk = ~clk;

    rlc_compressor #(.W(W), .CNT_W(CNT_W)) u_rlc_compressor (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_ready (smp_ready),
        .flush_req (flush_req),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_prev  (rec_prev),
        .rec_mask  (rec_mask),
        .rec_len   (rec_len)
    );

    typedef struct {
        logic [W-1:0]     prev;
        logic [W-1:0]     mask;
        logic [CNT_W-1:0] len;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cycles = 0;
    int   full_runs = 0;

    bit           m_active = 1'b0;
    logic [W-1:0] m_level  = '0;
    int           m_cnt    = 0;

    bit               was_stalled = 1'b0;
    logic [W-1:0]     held_prev;
    logic [W-1:0]     held_mask;
    logic [CNT_W-1:0] held_len;

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic exp_t mk(input logic [W-1:0] p, input logic [W-1:0] m,
                                input int n, input string t);
        exp_t e;
        e.prev = p; e.mask = m; e.len = CNT_W'(n); e.tag = t;
        return e;
    endfunction

    // model and monitor, evaluated between edges
    always @(negedge clk) begin
        if (rst_n) begin
            bit free;
            free = !rec_valid || rec_ready;
            check(smp_ready == (free && !flush_req), "R8/R7 smp_ready rule", smp_ready, free && !flush_req);
            if (was_stalled) begin
                check(rec_valid && rec_prev == held_prev && rec_mask == held_mask && rec_len == held_len,
                      "R8 stalled record changed", {rec_prev, rec_mask, rec_len}, {held_prev, held_mask, held_len});
            end
            was_stalled = rec_valid && !rec_ready;
            held_prev = rec_prev; held_mask = rec_mask; held_len = rec_len;
            if (rec_valid) begin
                check(rec_len != 0, "R9 zero length record", rec_len, 1);
            end
            if (rec_valid && rec_ready) begin
                if (rec_len == CNT_W'(LIMIT) && rec_mask == '0) full_runs++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected record", {rec_prev, rec_mask, rec_len}, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rec_prev == e.prev && rec_mask == e.mask && rec_len == e.len,
                          {e.tag, " record fields"}, {rec_prev, rec_mask, rec_len}, {e.prev, e.mask, e.len});
                end
            end
            if (flush_req && free) begin
                if (m_active) exp_q.push_back(mk(m_level, '0, m_cnt, "R6"));
                m_active = 1'b0;
                m_cnt = 0;
            end else if (smp_valid && smp_ready) begin
                if (!m_active) begin
                    m_active = 1'b1; m_level = smp_data; m_cnt = 1;
                end else if (smp_data != m_level) begin
                    exp_q.push_back(mk(m_level, m_level ^ smp_data, m_cnt, "R4"));
                    m_level = smp_data; m_cnt = 1;
                end else if (m_cnt == LIMIT) begin
                    exp_q.push_back(mk(m_level, '0, LIMIT, "R5"));
                    m_cnt = 1;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            check(1'b0, "watchdog expired", cycles, 190000);
            report();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit v, input logic [W-1:0] d, input bit f, input bit r);
        smp_valid = v; smp_data = d; flush_req = f; rec_ready = r;
    endtask

    logic [W-1:0] pool [4] = '{8'h00, 8'h0F, 8'hA5, 8'h5A};

    initial begin
        void'($urandom(32'd7719));
        repeat (3) step();
        @(negedge clk);
        check(rec_valid == 1'b0, "R1 rec_valid after reset", rec_valid, 0);
        check(smp_ready == 1'b1, "R1 smp_ready after reset", smp_ready, 1);
        rst_n = 1'b1;
        step();

        // R2: first sample opens a run silently
        drive(1, 8'h33, 0, 1); step();
        drive(0, 8'h33, 0, 1); @(negedge clk);
        check(rec_valid == 1'b0, "R2 record after first sample", rec_valid, 0);
        step();
        // R3: equal samples only count
        drive(1, 8'h33, 0, 1); step(); step();
        drive(0, 8'h33, 0, 1); @(negedge clk);
        check(rec_valid == 1'b0, "R3 record on equal sample", rec_valid, 0);
        step();
        // R4: change closes a run of 3
        drive(1, 8'h35, 0, 1); step();
        drive(0, 8'h35, 0, 1); step(); step();
        // R6: flush closes run of 1, then an empty flush
        drive(0, 8'h35, 1, 1); step();
        drive(0, 8'h35, 1, 1); step();
        drive(0, 8'h35, 0, 1); step(); @(negedge clk);
        check(rec_valid == 1'b0 && exp_q.size() == 0, "R6 empty flush produced record", rec_valid, 0);
        // R7: flush and sample together
        drive(1, 8'h77, 0, 1); step();
        drive(1, 8'h77, 1, 1); @(negedge clk);
        check(smp_ready == 1'b0, "R7 sample taken with flush", smp_ready, 0);
        step();
        drive(1, 8'h78, 0, 1); step();
        drive(0, 8'h78, 1, 0); step();
        // R8: back-pressure holds the record
        drive(1, 8'h78, 0, 0); @(negedge clk);
        check(rec_valid == 1'b1 && smp_ready == 1'b0, "R8 intake while stalled", smp_ready, 0);
        step(); step();
        drive(0, 8'h78, 0, 1); step(); step();

        // random mixture
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] d;
            d = ($urandom_range(0, 9) < 7) ? smp_data : pool[$urandom_range(0, 3)];
            drive($urandom_range(0, 3) != 0, d, $urandom_range(0, 39) == 0, $urandom_range(0, 3) != 0);
            step();
        end
        drive(0, smp_data, 1, 1); step();
        drive(0, smp_data, 0, 1); repeat (3) step();

        // R5: one run longer than the counter limit
        drive(1, 8'h3C, 0, 1);
        repeat (LIMIT + 10) step();
        drive(1, 8'hC3, 0, 1); step();
        drive(0, 8'hC3, 1, 1); step();
        drive(0, 8'hC3, 0, 1); repeat (4) step();
        @(negedge clk);
        check(full_runs >= 1, "R5 limit split not seen", full_runs, 1);
        check(exp_q.size() == 0, "R10 records still owed", exp_q.size(), 0);
        report();
    end

endmodule